// File: doc/BRIEF.md
# Low-Level Input Silence Gate

This block sits in front of a voice path that boosts gain. It stops faint background noise from being amplified while nobody is talking. Each valid 16-bit signed sample is reduced to its magnitude, and that magnitude is compared with a programmable 8-bit noise threshold. A counter tracks how many valid samples in a row have stayed below the threshold. When that run reaches a hold length, the gate replaces samples with exact zeros. It keeps doing so until a sample at or above the threshold arrives, and that sample reopens the gate at once.

The default hold length is 200 samples, which is 25 ms at an 8 kHz sample rate. The hold length is a parameter. The threshold can be reloaded at any time through a load strobe. An enable input switches the gate off. While the gate is off, samples pass through unchanged and the quiet run is forgotten. The output stream is registered, so it appears one cycle after the input. Each output sample comes with a flag that tells whether it was muted.

Top module: `quiet_gate`

## Requirements
- R1: After reset the threshold is 0x1F. When `thr_load` is high in a cycle, `thr_in` becomes the threshold from the next cycle on. A sample accepted in that same cycle is still judged against the old threshold.
- R2: The magnitude of a sample is its absolute value, and -32768 gives 32767. Any magnitude of 256 or more counts as at or above every threshold.
- R3: A sample is quiet only when its magnitude is strictly less than the threshold. A magnitude equal to the threshold counts as loud.
- R4: The quiet count advances by one for each valid quiet sample while enabled, and it saturates at the hold length. Cycles with `in_valid` low leave it unchanged.
- R5: While enabled, the quiet sample that completes a run of HOLD_SAMPLES consecutive quiet samples is output as 0 with `out_muted` high. Every later quiet sample is treated the same way. The sample before it in the run passes unchanged.
- R6: A loud sample clears the count. That same sample passes unchanged with `out_muted` low.
- R7: While `en` is low, valid samples pass unchanged with `out_muted` low, and the count is held at zero. After the gate is enabled again, a full new run is needed before it mutes.
- R8: `out_valid` equals `in_valid` delayed by one clock. `out_sample` and `out_muted` change only in the cycle after a valid input, and they hold their values otherwise.
- R9: During and right after reset, `out_valid`, `out_sample` and `out_muted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Gate enable; when low, samples bypass the gate |
| thr_load | input | 1 | Load strobe for the threshold |
| thr_in | input | 8 | New threshold value |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_sample | output | 16 | Gated sample |
| out_muted | output | 1 | High when the current output sample was forced to zero |

## Verification
The quiet counter and the threshold register are the only hidden state. Either one going wrong shows at the ports within one quiet run.

- A count that is off by one moves the first zeroed sample one position earlier or later. This is visible on the sample that should be exactly HOLD_SAMPLES into the run.
- A count that is not cleared by a loud sample, by the enable, or by reset makes the gate mute too early in the next run.
- A wrong or stale threshold flips the quiet/loud decision for samples whose magnitude lies near it. This is seen as a missed or spurious mute at the end of the next full run.
- Samples placed at exactly the threshold, at 256 and at -32768 expose faults in the compare and in the magnitude on a single output sample.

// File: rtl/quiet_gate.sv
module quiet_gate #(
  parameter int DATA_W = 16,
  parameter int THR_W = 8,
  parameter int HOLD_SAMPLES = 200,
  parameter logic [THR_W-1:0] THR_RESET = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              thr_load,
  input  logic [THR_W-1:0]  thr_in,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_sample,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_sample,
  output logic              out_muted
);
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
  localparam logic [CNT_W-1:0] HOLD_C = CNT_W'(HOLD_SAMPLES);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MOST_POS = {1'b0, {(DATA_W-1){1'b1}}};

  logic [THR_W-1:0]  thr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mag;
  logic [CNT_W-1:0]  cnt_inc;
  logic              quiet;
  logic              mute_now;

  assign mag = (in_sample == MOST_NEG) ? MOST_POS :
               (in_sample[DATA_W-1] ? (~in_sample + 1'b1) : in_sample);
  assign quiet = (mag[DATA_W-1:THR_W] == '0) && (mag[THR_W-1:0] < thr_q);
  assign cnt_inc = (cnt_q == HOLD_C) ? cnt_q : cnt_q + 1'b1;
  assign mute_now = en && quiet && (cnt_inc == HOLD_C);

  always_ff @(posedge clk) begin
    if (!rst_n) thr_q <= THR_RESET;
    else if (thr_load) thr_q <= thr_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (in_valid) cnt_q <= quiet ? cnt_inc : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
      out_muted  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sample <= mute_now ? '0 : in_sample;
        out_muted  <= mute_now;
      end
    end
  end
endmodule

// File: rtl/quiet_gate_chk.sv
module quiet_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        in_valid,
  input logic [15:0] in_sample,
  input logic        out_valid,
  input logic [15:0] out_sample,
  input logic        out_muted
);
  logic loud_big;
  assign loud_big = ($signed(in_sample) > 16'sd255) || ($signed(in_sample) < -16'sd255);

  // R8
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_sample) && $stable(out_muted)));
  // R5
  muted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_muted |-> (out_sample == 16'h0000));
  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> (!out_muted && out_sample == $past(in_sample)));
  // R2
  big_loud_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && loud_big) |=> (!out_muted && out_sample == $past(in_sample)));
endmodule

bind quiet_gate quiet_gate_chk u_quiet_gate_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_sample(out_sample), .out_muted(out_muted)
);

// File: tb/quiet_gate_bench.sv
module quiet_gate_bench;
  localparam int HOLD = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic thr_load = 1'b0;
  logic [7:0] thr_in = 8'h00;
  logic in_valid = 1'b0;
  logic [15:0] in_sample = 16'h0000;
  logic out_valid;
  logic [15:0] out_sample;
  logic out_muted;

  int checks = 0;
  int errors = 0;
  int m_thr = 8'h1F;
  int m_cnt = 0;
  logic e_valid = 1'b0;
  logic [15:0] e_sample = 16'h0000;
  logic e_muted = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  quiet_gate u_quiet_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .thr_load(thr_load), .thr_in(thr_in),
    .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample), .out_muted(out_muted)
  );

  function automatic int magnitude(logic [15:0] s);
    int v = $signed(s);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [15:0] s, bit e, bit ld, logic [7:0] t, string req);
    bit q;
    in_valid = v; in_sample = s; en = e; thr_load = ld; thr_in = t;
    e_valid = v;
    if (!e) m_cnt = 0;
    if (v) begin
      q = magnitude(s) < m_thr;
      if (!e) begin
        e_sample = s; e_muted = 1'b0;
      end else if (q) begin
        if (m_cnt < HOLD) m_cnt++;
        e_muted = (m_cnt == HOLD);
        e_sample = e_muted ? 16'h0000 : s;
      end else begin
        m_cnt = 0; e_sample = s; e_muted = 1'b0;
      end
    end
    if (ld) m_thr = t;
    @(negedge clk);
    check({req, " valid"}, out_valid, e_valid);
    check({req, " sample"}, out_sample, e_sample);
    check({req, " muted"}, out_muted, e_muted);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid", out_valid, 0);
    check("R9 sample", out_sample, 0);
    check("R9 muted", out_muted, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 default threshold 0x1F; R5 mute lands on the 200th quiet sample
    for (int i = 1; i <= HOLD + 3; i++) step(1, 16'hFFE2, 1, 0, 0, "R5");
    // R3 magnitude equal to threshold is loud; R6 reopens at once
    step(1, 16'h001F, 1, 0, 0, "R3");
    // R4 gaps leave count unchanged, R8 hold outputs
    for (int i = 1; i <= HOLD - 1; i++) begin
      step(1, 16'h0003, 1, 0, 0, "R4");
      step(0, 16'h7777, 1, 0, 0, "R8");
    end
    step(1, 16'h0003, 1, 0, 0, "R5");
    step(1, 16'hFFE1, 1, 0, 0, "R6");
    // R1 load: same-cycle sample uses old threshold
    step(1, 16'h0010, 1, 1, 8'h05, "R1");
    step(1, 16'h0010, 1, 0, 0, "R1");
    // R2 magnitudes 256 and -32768 loud at threshold 0xFF
    step(1, 16'h0000, 1, 1, 8'hFF, "R2");
    for (int i = 1; i <= HOLD + 2; i++) step(1, 16'h00FE, 1, 0, 0, "R2");
    step(1, 16'h0100, 1, 0, 0, "R2");
    for (int i = 1; i <= HOLD + 2; i++) step(1, 16'hFF01, 1, 0, 0, "R2");
    step(1, 16'h8000, 1, 0, 0, "R2");
    // R7 disable passes and clears count
    for (int i = 1; i <= HOLD - 1; i++) step(1, 16'h0001, 1, 0, 0, "R7");
    step(1, 16'h0001, 0, 0, 0, "R7");
    step(0, 16'h0000, 0, 0, 0, "R7");
    for (int i = 1; i <= HOLD + 1; i++) step(1, 16'h0001, 1, 0, 0, "R7");

    // random mix: R4 R5 R6 R8
    for (int i = 0; i < 6000; i++) begin
      bit v = ($urandom % 8) != 0;
      bit e = ($urandom % 200) != 0;
      bit ld = ($urandom % 500) == 0;
      logic [7:0] t = 8'(16 + $urandom % 24);
      int r = $urandom % 100;
      logic [15:0] s;
      if (r < 97) s = 16'($signed(($urandom % 31)) - 15);
      else if (r < 99) s = 16'($urandom);
      else s = 16'h8000;
      step(v, s, e, ld, t, "R5 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule